// File: doc/BRIEF.md
# Shared Interrupt Aggregator

This block gathers a wide set of peripheral interrupt inputs onto four shared interrupt lines toward a processor. Each input passes through a synchronizer. A rising edge of the synchronized input sets a pending bit, and the pending bits are held in 32-bit status words. Each of the four output lines has its own bank of enable words covering every source. A line requests service when some pending source that its bank enables is set.

Software uses a small word-addressed register port. It can read the status words, drop pending bits by writing a mask of ones to a clear word, and read or write every enable word. Bit 0 of the first enable word in each bank is that line's master switch. Because of this, source 0 cannot be routed to any line. Turning the master switch off and then on again drives the line low for at least one cycle. A downstream edge detector therefore sees a fresh rising edge whenever enabled work is still pending.

Top module: `shared_irq_agg`

## Requirements
- R1: After reset, irq_out is 0, every status word reads 0 and every enable word reads 0.
- R2: Source n sets bit n mod 32 of status word n / 32. The bit is set on the second clock edge after the edge that first samples src_in[n] high. A level that stays high does not set it again.
- R3: A pending bit survives while its source is disabled and raises the line once the enable bit is set. If it was cleared before the enable, the line stays low.
- R4: Writing a mask to clear word w (address 2 + w) clears exactly the pending bits of status word w that are 1 in the mask. Bits that are 0 in the mask keep their value.
- R5: When a new capture and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R6: irq_out[o] is registered. Its value is master_o AND the OR over all words of (status AND enable word of bank o), with bit 0 of word 0 excluded. A pending source 0 never raises any line.
- R7: When the master bit of bank o is 0, irq_out[o] is low on the following edge. Setting the master bit again gives at least one low cycle and then a new rising edge if enabled sources are still pending.
- R8: The four banks are independent. Enabling a source in one bank does not affect the other lines.
- R9: Word address map: status words at 0 and 1 (read-only, writes ignored); clear words at 2 and 3 (write-only, read as 0); enable word w of bank o at 4 + 2*o + w. Every other address reads 0.
- R10: bus_rdata carries the addressed word one cycle after bus_rd is sampled high, and is 0 in every other cycle.
- R11: Writing zero to every enable word of every bank holds all lines low while the pending bits stay in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Asynchronous interrupt source levels |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 4 | Shared interrupt lines |

## Verification
The operations that can fall on the same edge are a fresh capture from a synchronized source and a software clear of the same pending bit. The bench holds a bit already pending, drops its source, then raises it again. It places the clear write exactly two edges after the edge that samples the new high. A read of the status word afterwards must still show the bit set. The behavioural model compared every cycle must agree with the design on that cycle.

// File: rtl/sia_pkg.sv
package sia_pkg;

  typedef enum logic [1:0] {
    REG_STATUS,
    REG_CLEAR,
    REG_ENABLE,
    REG_NONE
  } reg_kind_e;

  // Map a word address onto its region of the register layout.
  function automatic reg_kind_e classify(input int addr, input int n_words, input int n_out);
    if (addr < n_words)                        return REG_STATUS;
    else if (addr < 2 * n_words)               return REG_CLEAR;
    else if (addr < 2 * n_words + n_out * n_words) return REG_ENABLE;
    return REG_NONE;
  endfunction

endpackage

// File: rtl/sia_edge_sync.sv
module sia_edge_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] stg [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= async_in;
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign rise = stg[STAGES-1] & ~stg[STAGES];

endmodule

// File: rtl/sia_pend_store.sv
module sia_pend_store #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [WORD_W*NUM_WORDS-1:0]   rise,
  input  logic [NUM_WORDS-1:0]          clr_we,
  input  logic [WORD_W-1:0]             clr_mask,
  output logic [WORD_W*NUM_WORDS-1:0]   pend
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        // a capture on this edge outranks a clear on this edge
        pend[w*WORD_W +: WORD_W] <=
          (pend[w*WORD_W +: WORD_W] & ~(clr_we[w] ? clr_mask : '0))
          | rise[w*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/sia_out_bank.sv
module sia_out_bank #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_WORDS-1:0]        we,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [WORD_W*NUM_WORDS-1:0] pend,
  output logic [WORD_W*NUM_WORDS-1:0] en_words,
  output logic                        irq
);

  localparam int NSRC = WORD_W * NUM_WORDS;
  localparam logic [NSRC-1:0] SRC_MASK = ~NSRC'(1);

  logic master;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_words <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (we[w]) en_words[w*WORD_W +: WORD_W] <= wdata;
    end
  end

  assign master = en_words[0];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= master & (|(pend & en_words & SRC_MASK));
  end

endmodule

// File: rtl/shared_irq_agg.sv
module shared_irq_agg #(
  parameter int NUM_OUT     = 4,
  parameter int WORD_W      = 32,
  parameter int NUM_WORDS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [WORD_W*NUM_WORDS-1:0]   src_in,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [WORD_W-1:0]             bus_wdata,
  output logic [WORD_W-1:0]             bus_rdata,
  output logic [NUM_OUT-1:0]            irq_out
);
  import sia_pkg::*;

  localparam int NUM_SRC  = WORD_W * NUM_WORDS;
  localparam int CLR_BASE = NUM_WORDS;
  localparam int EN_BASE  = 2 * NUM_WORDS;
  localparam int EN_WORDS = NUM_OUT * NUM_WORDS;

  logic [NUM_SRC-1:0]         src_rise;
  logic [NUM_SRC-1:0]         pend;
  logic [NUM_OUT*NUM_SRC-1:0] en_all;
  logic [NUM_WORDS-1:0]       clr_we;
  logic [EN_WORDS-1:0]        en_we;
  logic [WORD_W-1:0]          rd_val;
  reg_kind_e                  kind;
  int                         word_sel;

  sia_edge_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(src_in), .rise(src_rise)
  );

  sia_pend_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_pend (
    .clk(clk), .rst(rst), .rise(src_rise), .clr_we(clr_we),
    .clr_mask(bus_wdata), .pend(pend)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_bank
    sia_out_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_bank (
      .clk(clk), .rst(rst),
      .we(en_we[o*NUM_WORDS +: NUM_WORDS]),
      .wdata(bus_wdata),
      .pend(pend),
      .en_words(en_all[o*NUM_SRC +: NUM_SRC]),
      .irq(irq_out[o])
    );
  end

  always_comb begin
    word_sel = int'(bus_addr);
    kind     = classify(word_sel, NUM_WORDS, NUM_OUT);
    for (int w = 0; w < NUM_WORDS; w++)
      clr_we[w] = bus_wr && (kind == REG_CLEAR) && (word_sel == CLR_BASE + w);
    for (int j = 0; j < EN_WORDS; j++)
      en_we[j] = bus_wr && (kind == REG_ENABLE) && (word_sel == EN_BASE + j);
  end

  always_comb begin
    rd_val = '0;
    case (kind)
      REG_STATUS: begin
        for (int w = 0; w < NUM_WORDS; w++)
          if (word_sel == w) rd_val = pend[w*WORD_W +: WORD_W];
      end
      REG_ENABLE: begin
        for (int j = 0; j < EN_WORDS; j++)
          if (word_sel == EN_BASE + j) rd_val = en_all[j*WORD_W +: WORD_W];
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

endmodule

// File: rtl/sia_checker.sv
module sia_checker #(
  parameter int NUM_OUT   = 4,
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 4
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic [ADDR_W-1:0]                     bus_addr,
  input logic                                  bus_wr,
  input logic                                  bus_rd,
  input logic [WORD_W-1:0]                     bus_wdata,
  input logic [WORD_W-1:0]                     bus_rdata,
  input logic [NUM_OUT-1:0]                    irq_out,
  input logic [WORD_W*NUM_WORDS-1:0]           src_rise,
  input logic [WORD_W*NUM_WORDS-1:0]           pend,
  input logic [NUM_OUT*WORD_W*NUM_WORDS-1:0]   en_all
);
  localparam int NSRC = WORD_W * NUM_WORDS;
  localparam logic [NSRC-1:0] SRC_MASK = ~NSRC'(1);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_out == '0 && bus_rdata == '0));

  p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (|src_rise) |=> ((pend & $past(src_rise)) == $past(src_rise)));

  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(NUM_WORDS + w)) |=>
      ((pend[w*WORD_W +: WORD_W] & $past(bus_wdata & ~src_rise[w*WORD_W +: WORD_W])) == '0));
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_o
    p_master_low_r7: assert property (@(posedge clk) disable iff (rst)
      !en_all[o*NSRC] |=> !irq_out[o]);
    p_rise_cause_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_out[o]) |->
      $past(en_all[o*NSRC] && (|(pend & en_all[o*NSRC +: NSRC] & SRC_MASK))));
  end

endmodule

bind shared_irq_agg sia_checker #(
  .NUM_OUT(NUM_OUT), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .src_rise(src_rise), .pend(pend), .en_all(en_all)
);

// File: tb/tb_shared_irq_agg.sv
module tb_shared_irq_agg;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  shared_irq_agg dut (
    .clk(clk), .rst(rst), .src_in(src), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_s0, m_s1, m_s2, m_pend, m_rise, m_np, m_bank;
  logic [31:0] m_en [4][2];
  logic [31:0] m_rdata;
  logic [3:0]  m_irq;
  int          m_a;

  always @(posedge clk) begin
    if (rst) begin
      m_s0 = '0; m_s1 = '0; m_s2 = '0; m_pend = '0; m_rdata = '0; m_irq = '0;
      for (int o = 0; o < 4; o++) begin m_en[o][0] = '0; m_en[o][1] = '0; end
    end else begin
      m_a    = int'(bus_addr);
      m_rise = m_s1 & ~m_s2;
      for (int o = 0; o < 4; o++) begin
        m_bank   = {m_en[o][1], m_en[o][0]};
        m_irq[o] = m_en[o][0][0] & (|(m_pend & m_bank & ~64'd1));
      end
      if (bus_rd) begin
        if (m_a == 0)                 m_rdata = m_pend[31:0];
        else if (m_a == 1)            m_rdata = m_pend[63:32];
        else if (m_a >= 4 && m_a < 12) m_rdata = m_en[(m_a-4)/2][(m_a-4)%2];
        else                          m_rdata = '0;
      end else begin
        m_rdata = '0;
      end
      m_np = m_pend;
      if (bus_wr && m_a == 2) m_np[31:0]  = m_np[31:0]  & ~bus_wdata;
      if (bus_wr && m_a == 3) m_np[63:32] = m_np[63:32] & ~bus_wdata;
      m_pend = m_np | m_rise;
      if (bus_wr && m_a >= 4 && m_a < 12) m_en[(m_a-4)/2][(m_a-4)%2] = bus_wdata;
      m_s2 = m_s1; m_s1 = m_s0; m_s0 = src;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq_out === m_irq, "R6 model irq_out", {28'd0, irq_out}, {28'd0, m_irq});
      chk(bus_rdata === m_rdata, "R10 model bus_rdata", bus_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 4'(a); bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(1);
    chk(irq_out == 4'd0, "R1 irq after reset", {28'd0, irq_out}, 32'd0);
    rd(0, v); chk(v == 32'd0, "R1 status after reset", v, 32'd0);
    rd(4, v); chk(v == 32'd0, "R1 enable after reset", v, 32'd0);

    // R2 / R6: source 37 routed to line 0
    wr(4, 32'h1); wr(5, 32'h20);
    src[37] = 1'b1; idle(5);
    chk(irq_out == 4'b0001, "R6 line 0 raised", {28'd0, irq_out}, 32'h1);
    rd(1, v); chk(v == 32'h20, "R2 word 1 bit 5", v, 32'h20);

    // R8: bank 1 independent
    wr(6, 32'h9);
    src[3] = 1'b1; idle(5);
    chk(irq_out == 4'b0011, "R8 independent banks", {28'd0, irq_out}, 32'h3);

    // R4: clear by mask
    wr(2, 32'h10);
    rd(0, v); chk(v == 32'h8, "R4 zero mask bits kept", v, 32'h8);
    wr(3, 32'h20); idle(1);
    chk(irq_out[0] == 1'b0, "R4 line drops after clear", {31'd0, irq_out[0]}, 32'd0);
    rd(1, v); chk(v == 32'd0, "R4 bit cleared", v, 32'd0);

    // R3: pending while disabled
    src[40] = 1'b1; idle(5);
    chk(irq_out[0] == 1'b0, "R3 disabled source quiet", {31'd0, irq_out[0]}, 32'd0);
    rd(1, v); chk(v == 32'h100, "R3 pending kept", v, 32'h100);
    wr(5, 32'h120); idle(1);
    chk(irq_out[0] == 1'b1, "R3 delivered on enable", {31'd0, irq_out[0]}, 32'd1);
    wr(3, 32'h100);
    src[41] = 1'b1; idle(5);
    wr(3, 32'h200); wr(5, 32'h320); idle(2);
    chk(irq_out[0] == 1'b0, "R3 cleared before enable", {31'd0, irq_out[0]}, 32'd0);

    // R7: master toggle
    src[42] = 1'b1; wr(5, 32'h720); idle(5);
    chk(irq_out[0] == 1'b1, "R7 line high before toggle", {31'd0, irq_out[0]}, 32'd1);
    wr(4, 32'h0); idle(1);
    chk(irq_out[0] == 1'b0, "R7 master off", {31'd0, irq_out[0]}, 32'd0);
    wr(4, 32'h1);
    chk(irq_out[0] == 1'b0, "R7 low cycle", {31'd0, irq_out[0]}, 32'd0);
    idle(1);
    chk(irq_out[0] == 1'b1, "R7 new edge", {31'd0, irq_out[0]}, 32'd1);
    wr(4, 32'h0); wr(4, 32'h1);
    chk(irq_out[0] == 1'b0, "R7 back-to-back low", {31'd0, irq_out[0]}, 32'd0);
    idle(1);
    chk(irq_out[0] == 1'b1, "R7 back-to-back edge", {31'd0, irq_out[0]}, 32'd1);

    // R6: source 0 not routable
    wr(8, 32'h1);
    src[0] = 1'b1; idle(5);
    chk(irq_out[2] == 1'b0, "R6 source 0 never routed", {31'd0, irq_out[2]}, 32'd0);
    rd(0, v); chk(v == 32'h9, "R2 source 0 pending", v, 32'h9);

    // R5: capture and clear on the same edge
    src[11] = 1'b1; idle(4); src[11] = 1'b0; idle(4);
    rd(0, v); chk(v == 32'h809, "R5 setup pending", v, 32'h809);
    src[11] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(2, 32'h800);
    rd(0, v); chk(v == 32'h809, "R5 capture beats clear", v, 32'h809);

    // R9: register map
    rd(2, v);  chk(v == 32'd0, "R9 clear word reads 0", v, 32'd0);
    rd(14, v); chk(v == 32'd0, "R9 unmapped reads 0", v, 32'd0);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v);  chk(v == 32'h809, "R9 status read-only", v, 32'h809);
    wr(11, 32'hA5A5_0000);
    rd(11, v); chk(v == 32'hA5A5_0000, "R9 enable readback", v, 32'hA5A5_0000);
    rd(6, v);  chk(v == 32'h9, "R9 bank 1 word 0 address", v, 32'h9);

    // R10: idle read data
    idle(1);
    chk(bus_rdata == 32'd0, "R10 rdata idle", bus_rdata, 32'd0);

    // R11: disable everything
    for (int a = 4; a < 12; a++) wr(a, 32'd0);
    idle(1);
    chk(irq_out == 4'd0, "R11 all lines low", {28'd0, irq_out}, 32'd0);
    rd(0, v); chk(v == 32'h809, "R11 pending kept", v, 32'h809);

    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_err);
    $finish;
  end

endmodule